// File: doc/BRIEF.md
# Aligned Fetch Chunk Byte Buffer

This block sits between an instruction cache and a variable-length instruction decoder. Fetch does not need to know instruction lengths. Each cycle the cache can hand over one naturally aligned chunk of code bytes. The buffer appends the useful part of that chunk to a byte queue. The decoder sees a window that starts at the oldest unused byte. Each cycle the decoder states how many bytes it took, and those bytes leave the queue. Bytes the decoder did not use stay in the queue and lead the next decode group.

When control flow is redirected, the queue is flushed. The low address bits of the target give the target's offset inside its aligned chunk. The first chunk accepted after the redirect loses every byte below that offset. A target in the last byte of a chunk therefore yields a single useful byte. Since every chunk is aligned, no fetch group ever crosses a cache line boundary.

Top module: `chunk_byte_buffer`

## Requirements
- R1: After reset the window is empty (`out_cnt` = 0) and `in_ready` is 1.
- R2: An accepted chunk's bytes are appended in address order behind the bytes already held. Byte i of the window (`out_data[8*i+7:8*i]`) is the i-th oldest held byte. `out_cnt` is min(held bytes, 16).
- R3: `cons_cnt` bytes are removed from the head of the queue at the clock edge. The remaining bytes shift to the head of the window in the next cycle. `cons_cnt` never exceeds `out_cnt`.
- R4: `in_ready` is 1 exactly when at least 16 of the 32 byte slots are free, that is, when at most 16 bytes are held.
- R5: A chunk presented while `in_ready` is 0 is ignored and leaves the queue unchanged.
- R6: A redirect empties the queue, and `out_cnt` is 0 in the following cycle. A chunk or a consume count presented in the redirect cycle is ignored.
- R7: The first chunk accepted after a redirect drops its bytes below offset `redir_off`. An offset of 15 leaves one byte, chunk byte 15. Later chunks are taken whole.
- R8: Suppose the decoder consumes every valid byte while a new chunk is accepted in the same cycle. In the next cycle that chunk's first byte is at the head of the window, with no empty cycle between.
- R9: The queue never holds more than 32 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Chunk from the cache is valid |
| in_data | input | 128 | Aligned chunk; byte j at bits 8j+7:8j |
| in_ready | output | 1 | Buffer can take a chunk this cycle |
| redir_valid | input | 1 | Redirect: flush and set the drop offset |
| redir_off | input | 4 | Low address bits of the redirect target |
| cons_cnt | input | 5 | Bytes the decoder consumed this cycle |
| out_data | output | 128 | Decode window; byte i at bits 8i+7:8i |
| out_cnt | output | 5 | Number of valid bytes in the window |

## Verification
Every result appears one clock edge after its stimulus, because the window, `out_cnt` and `in_ready` all come from registered state. The bench drives inputs on the falling edge. It checks `in_ready` before the rising edge and checks the window and count 1 ns after that edge, against a byte-queue model advanced by one step. Directed sequences cover full-buffer back-pressure, a flush to offset 15, and consume-all with a chunk arriving in the same cycle. Seeded random traffic then covers the rest.

// File: rtl/chunk_byte_buffer.sv
module chunk_byte_buffer #(
  parameter int CHUNK = 16,
  parameter int DEPTH = 32,
  parameter int WIN   = 16,
  localparam int OFF_W  = $clog2(CHUNK),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int WCNT_W = $clog2(WIN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [CHUNK*8-1:0] in_data,
  output logic               in_ready,
  input  logic               redir_valid,
  input  logic [OFF_W-1:0]   redir_off,
  input  logic [WCNT_W-1:0]  cons_cnt,
  output logic [WIN*8-1:0]   out_data,
  output logic [WCNT_W-1:0]  out_cnt
);

  logic [7:0]       q   [DEPTH];
  logic [7:0]       q_n [DEPTH];
  logic [CNT_W-1:0] cnt, cnt_n, rem;
  logic [OFF_W-1:0] skip;
  logic             accept;

  assign in_ready = cnt <= CNT_W'(DEPTH - CHUNK);
  assign accept   = in_valid && in_ready && !redir_valid;
  assign rem      = cnt - CNT_W'(cons_cnt);
  assign out_cnt  = (cnt > CNT_W'(WIN)) ? WCNT_W'(WIN) : WCNT_W'(cnt);

  for (genvar g = 0; g < WIN; g++) begin : g_win
    assign out_data[8*g +: 8] = q[g];
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      q_n[i] = 8'h00;
      if (i + int'(cons_cnt) < DEPTH) q_n[i] = q[i + int'(cons_cnt)];
    end
    if (accept) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i >= int'(rem) && (i - int'(rem) + int'(skip)) < CHUNK)
          q_n[i] = in_data[8*(i - int'(rem) + int'(skip)) +: 8];
      end
    end
    if (redir_valid)  cnt_n = '0;
    else if (accept)  cnt_n = rem + CNT_W'(CHUNK) - CNT_W'(skip);
    else              cnt_n = rem;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      skip <= '0;
    end else begin
      cnt <= cnt_n;
      if (redir_valid) skip <= redir_off;
      else if (accept) skip <= '0;
    end
    q <= q_n;
  end

  p_cons_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |-> cons_cnt <= out_cnt);

  p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && !(in_valid && in_ready)) |=> cnt == $past(cnt) - CNT_W'($past(cons_cnt)));

  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> out_cnt == '0);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  p_no_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !redir_valid && cons_cnt == out_cnt) |=> out_cnt != '0);

  p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_cnt == WCNT_W'(WIN));

endmodule

// File: tb/test_chunk_byte_buffer.sv
`timescale 1ns/1ps
module test_chunk_byte_buffer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_data;
  logic         in_ready;
  logic         redir_valid;
  logic [3:0]   redir_off;
  logic [4:0]   cons_cnt;
  logic [127:0] out_data;
  logic [4:0]   out_cnt;

  always #2.5 clk = ~clk;

  chunk_byte_buffer i_chunk_byte_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .redir_valid(redir_valid), .redir_off(redir_off),
    .cons_cnt(cons_cnt), .out_data(out_data), .out_cnt(out_cnt));

  byte unsigned mdl[$];
  int skip_m = 0;
  int vec = 0;
  int bad = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int win_cnt();
    return (mdl.size() > 16) ? 16 : mdl.size();
  endfunction

  function automatic logic [127:0] rnd_chunk();
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[32*k +: 32] = $urandom;
    return d;
  endfunction

  task automatic cycle(bit v, logic [127:0] d, bit rd, int off, int cons);
    bit rdy_m, acc;
    int c;
    c = (cons > win_cnt()) ? win_cnt() : cons;
    @(negedge clk);
    in_valid = v; in_data = d; redir_valid = rd;
    redir_off = 4'(off); cons_cnt = 5'(c);
    rdy_m = mdl.size() <= 16;
    #1;
    chk(in_ready == rdy_m, "R4", "in_ready", int'(in_ready), int'(rdy_m));
    @(posedge clk);
    #1;
    acc = v && rdy_m && !rd;
    if (rd) begin
      mdl.delete();
      skip_m = off;
    end else begin
      for (int k = 0; k < c; k++) void'(mdl.pop_front());
      if (acc) begin
        for (int k = skip_m; k < 16; k++) mdl.push_back(d[8*k +: 8]);
        skip_m = 0;
      end
    end
    chk(mdl.size() <= 32, "R9", "model depth", mdl.size(), 32);
    chk(int'(out_cnt) == win_cnt(), "R2", "out_cnt", int'(out_cnt), win_cnt());
    for (int k = 0; k < win_cnt(); k++)
      chk(out_data[8*k +: 8] == mdl[k], "R2", "window byte",
          int'(out_data[8*k +: 8]), int'(mdl[k]));
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [127:0] da, db, dc, dy, dz;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; redir_valid = 1'b0;
    redir_off = '0; cons_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_cnt == 5'd0, "R1", "reset out_cnt", int'(out_cnt), 0);
    chk(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);

    da = rnd_chunk(); db = rnd_chunk(); dc = rnd_chunk();
    cycle(1, da, 0, 0, 0);
    cycle(1, db, 0, 0, 0);
    chk(in_ready == 1'b0, "R9", "full in_ready", int'(in_ready), 0);
    cycle(1, dc, 0, 0, 0);
    cycle(0, '0, 0, 0, 16);
    chk(out_data == db, "R5", "window after ignored chunk",
        int'(out_data[7:0]), int'(db[7:0]));
    cycle(0, '0, 0, 0, 16);
    chk(out_cnt == 5'd0, "R5", "drained count", int'(out_cnt), 0);

    cycle(1, rnd_chunk(), 0, 0, 0);
    cycle(1, rnd_chunk(), 1, 15, 7);
    chk(out_cnt == 5'd0, "R6", "flush count", int'(out_cnt), 0);
    dy = rnd_chunk();
    cycle(1, dy, 0, 0, 0);
    chk(out_cnt == 5'd1, "R7", "offset 15 count", int'(out_cnt), 1);
    chk(out_data[7:0] == dy[127:120], "R7", "offset 15 byte",
        int'(out_data[7:0]), int'(dy[127:120]));
    dz = rnd_chunk();
    cycle(1, dz, 0, 0, 1);
    chk(out_data[7:0] == dz[7:0], "R8", "head after consume-all",
        int'(out_data[7:0]), int'(dz[7:0]));
    chk(out_cnt == 5'd16, "R7", "later chunk whole", int'(out_cnt), 16);
    cycle(0, '0, 0, 0, 5);
    chk(out_cnt == 5'd11, "R3", "count after consume", int'(out_cnt), 11);
    chk(out_data[7:0] == dz[47:40], "R3", "head after consume",
        int'(out_data[7:0]), int'(dz[47:40]));

    for (int n = 0; n < 3000; n++) begin
      bit v, rd;
      v  = ($urandom_range(0, 3) != 0);
      rd = ($urandom_range(0, 19) == 0);
      cycle(v, rnd_chunk(), rd, int'($urandom_range(0, 15)),
            int'($urandom_range(0, 16)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule